// File: doc/BRIEF.md
# Debug APB Slave Access Gate

This block is an APB slave that sits in front of two register windows, one for debug registers and one for performance-monitor registers. The top bit of the word address picks the window; the low bits pick a word inside it. Each window has its own storage bank. Each bank has a fixed number of wait states, and the block stalls the transfer by holding `pready` low for that many access cycles. Storage is written so that block RAM can be inferred.

A sideband input marks where each transfer came from: the external debugger or another master. The block captures it in the setup phase. The debug window is protected: a transfer from a master other than the debugger gets a slave error. Its write is dropped and its read data is zero. A word offset beyond a window's depth is refused the same way, in both windows.

One word of the debug window is a control register. Bit 0 of that register is the secure-user invasive-debug enable. Together with the secure invasive-debug enable pin, this bit sets two registered permission outputs. Halting debug in secure user state is allowed only when the pin is high. The control bit alone allows only monitor-mode debug.

Top module: `dbg_apb_gate`

## Requirements
- R1: The access phase of a debug-window transfer lasts `DBG_WAIT`+1 cycles and that of a performance-window transfer lasts `PMU_WAIT`+1 cycles. `pready` is high only in the last of these cycles.
- R2: Word-address bit `paddr[ADDR_W-1]` selects the window: 0 selects the debug window and 1 selects the performance window. The two windows share the same word indices but have separate storage.
- R3: A completed 32-bit write is returned unchanged by a later read of the same window and word.
- R4: A transfer to the debug window with `src_dbg`=0 ends with `pslverr`=1. Its write is discarded and its `prdata` is 0. When `src_dbg`=1, or for any in-range transfer to the performance window, `pslverr` is 0.
- R5: In the debug window, the word at offset `CTRL_WORD` is the control register. It reads as {31'b0, enable bit}, a completed write loads the enable bit from `pwdata[0]`, and the bit is 0 after reset.
- R6: `halt_su_ok` equals `sec_inv_en` as registered one cycle earlier. It is 0 whenever the pin was low, even if the enable bit is 1.
- R7: `mon_su_ok` equals (`sec_inv_en` OR enable bit) as registered one cycle earlier.
- R8: A word offset (`paddr[ADDR_W-2:0]`) of `DEPTH` or more ends with `pslverr`=1. Its write is discarded and its `prdata` is 0.
- R9: Synchronous active-high `rst` clears the enable bit, `pready`, `pslverr`, `halt_su_ok` and `mon_su_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Word address; the MSB selects the window |
| pwdata | input | 32 | Write data |
| src_dbg | input | 1 | Access source: 1 = external debugger |
| sec_inv_en | input | 1 | Secure invasive-debug enable pin |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Slave error on the completing cycle |
| halt_su_ok | output | 1 | Halting debug allowed in secure user state |
| mon_su_ok | output | 1 | Monitor debug allowed in secure user state |

## Verification
The bench uses the default parameters: 11 address bits, 16 words per window, the control register at word 5, one wait state in the debug window and two in the performance window. The two wait counts differ, so a single run can tell the windows apart by their stall lengths. A depth of 16 leaves plenty of offsets above the depth for the out-of-range error. The control word sits in the middle of a small window, so its readback override, its protection and its aliasing with the performance window are all reachable in a few transfers.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_WIN = 2;

  typedef enum logic {
    WIN_DEBUG = 1'b0,
    WIN_PERF  = 1'b1
  } win_e;
endpackage

// File: rtl/dbg_win_bank.sv
module dbg_win_bank #(
  parameter int DEPTH   = 16,
  parameter int WAIT    = 1,
  parameter bit PROTECT = 1'b0,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CW     = $clog2(WAIT + 2)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sel,
  input  logic                            en,
  input  logic                            wr,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            oor,
  input  logic                            src,
  input  logic [dbg_gate_pkg::DATA_W-1:0] wdata,
  output logic [dbg_gate_pkg::DATA_W-1:0] rdata,
  output logic                            rdy,
  output logic                            err
);
  import dbg_gate_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [CW-1:0]     cnt;
  logic              rdy_q, err_q;
  logic              refuse;

  assign refuse = oor | (PROTECT & ~src);

  // Storage: no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (sel && en && rdy_q && !err_q && wr)
      mem[idx] <= wdata;
    rd_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0;
      err_q <= 1'b0;
      cnt   <= '0;
    end else if (sel && !en) begin
      cnt   <= CW'(WAIT);
      rdy_q <= (WAIT == 0);
      err_q <= refuse;
    end else if (sel && en) begin
      if (rdy_q) begin
        rdy_q <= 1'b0;
      end else begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1))
          rdy_q <= 1'b1;
      end
    end
  end

  assign rdata = rd_q;
  assign rdy   = rdy_q;
  assign err   = err_q;

  // R1
  setup_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !en) |=> (rdy == (WAIT == 0)));
endmodule

// File: rtl/dbg_auth_eval.sv
module dbg_auth_eval (
  input  logic clk,
  input  logic rst,
  input  logic sec_pin,
  input  logic su_bit,
  output logic halt_ok,
  output logic mon_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_ok <= 1'b0;
      mon_ok  <= 1'b0;
    end else begin
      halt_ok <= sec_pin;
      mon_ok  <= sec_pin | su_bit;
    end
  end

  // R6
  halt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_pin |=> !halt_ok);
  // R7
  mon_follow_chk: assert property (@(posedge clk) disable iff (rst)
    su_bit |=> mon_ok);
endmodule

// File: rtl/dbg_apb_gate.sv
module dbg_apb_gate #(
  parameter int ADDR_W    = 11,
  parameter int DEPTH     = 16,
  parameter int CTRL_WORD = 5,
  parameter int DBG_WAIT  = 1,
  parameter int PMU_WAIT  = 2,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int OFF_W    = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic              src_dbg,
  input  logic              sec_inv_en,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              halt_su_ok,
  output logic              mon_su_ok
);
  import dbg_gate_pkg::*;

  localparam int WAITS [NUM_WIN] = '{DBG_WAIT, PMU_WAIT};

  win_e              win;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  idx;
  logic              oor;
  logic [DATA_W-1:0] rdata_w [NUM_WIN];
  logic              rdy_w   [NUM_WIN];
  logic              err_w   [NUM_WIN];
  logic              su_bit, ctrl_hit_q;
  logic              done, ctrl_addr;

  assign win       = win_e'(paddr[ADDR_W-1]);
  assign off       = paddr[OFF_W-1:0];
  assign idx       = off[IDX_W-1:0];
  assign oor       = (off >= OFF_W'(DEPTH));
  assign ctrl_addr = (win == WIN_DEBUG) && (off == OFF_W'(CTRL_WORD));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    dbg_win_bank #(
      .DEPTH   (DEPTH),
      .WAIT    (WAITS[w]),
      .PROTECT (w == int'(WIN_DEBUG))
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .sel   (psel && (int'(win) == w)),
      .en    (penable),
      .wr    (pwrite),
      .idx   (idx),
      .oor   (oor),
      .src   (src_dbg),
      .wdata (pwdata),
      .rdata (rdata_w[w]),
      .rdy   (rdy_w[w]),
      .err   (err_w[w])
    );
  end

  assign pready  = rdy_w[win];
  assign pslverr = rdy_w[win] & err_w[win];
  assign done    = psel && penable && pready;

  always_comb begin
    if (err_w[win])
      prdata = '0;
    else if (ctrl_hit_q)
      prdata = {31'b0, su_bit};
    else
      prdata = rdata_w[win];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      su_bit     <= 1'b0;
      ctrl_hit_q <= 1'b0;
    end else begin
      if (psel && !penable)
        ctrl_hit_q <= ctrl_addr;
      if (done && pwrite && !pslverr && ctrl_addr)
        su_bit <= pwdata[0];
    end
  end

  dbg_auth_eval u_auth (
    .clk     (clk),
    .rst     (rst),
    .sec_pin (sec_inv_en),
    .su_bit  (su_bit),
    .halt_ok (halt_su_ok),
    .mon_ok  (mon_su_ok)
  );

  // R4
  err_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (done && pslverr) |=> $stable(su_bit));
  // R5
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (done && pwrite && !pslverr && ctrl_addr) |=> (su_bit == $past(pwdata[0])));
endmodule

// File: tb/sim_dbg_apb_gate.sv
module sim_dbg_apb_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [10:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic        src_dbg = 1'b1, sec_inv_en = 1'b0;
  logic [31:0] prdata;
  logic        pready, pslverr, halt_su_ok, mon_su_ok;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  dbg_apb_gate u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .src_dbg(src_dbg), .sec_inv_en(sec_inv_en),
    .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .halt_su_ok(halt_su_ok), .mon_su_ok(mon_su_ok)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input bit win, input int word,
                      input logic [31:0] data, input bit src,
                      output logic [31:0] rd, output bit er, output int waits);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = {win, 10'(word)};
    pwdata = data; src_dbg = src;
    @(negedge clk);
    penable = 1;
    waits = 0;
    #1;
    while (!pready && waits < 20) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = prdata; er = pslverr;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; bit er; int w;
    check(pready == 0 && pslverr == 0, "R9 pready/pslverr", {pready, pslverr}, 0);
    check(halt_su_ok == 0 && mon_su_ok == 0, "R9 permissions", {halt_su_ok, mon_su_ok}, 0);
    xfer(0, 0, 5, 0, 1, rd, er, w);
    check(rd == 0, "R5 ctrl reset value", rd, 0);
  endtask

  task automatic t_debug_rw();
    logic [31:0] rd; bit er; int w;
    xfer(1, 0, 3, 32'hCAFE_0003, 1, rd, er, w);
    check(w == 1, "R1 debug wait states", w, 1);
    check(er == 0, "R4 debugger write ok", er, 0);
    xfer(0, 0, 3, 0, 1, rd, er, w);
    check(rd == 32'hCAFE_0003, "R3 debug readback", rd, 32'hCAFE_0003);
  endtask

  task automatic t_perf_rw();
    logic [31:0] rd; bit er; int w;
    xfer(1, 1, 3, 32'h5A5A_1111, 0, rd, er, w);
    check(w == 2, "R1 perf wait states", w, 2);
    check(er == 0, "R4 perf open to other source", er, 0);
    xfer(0, 1, 3, 0, 0, rd, er, w);
    check(rd == 32'h5A5A_1111, "R3 perf readback", rd, 32'h5A5A_1111);
    xfer(0, 0, 3, 0, 1, rd, er, w);
    check(rd == 32'hCAFE_0003, "R2 windows separate", rd, 32'hCAFE_0003);
  endtask

  task automatic t_protect();
    logic [31:0] rd; bit er; int w;
    xfer(1, 0, 3, 32'hDEAD_BEEF, 0, rd, er, w);
    check(er == 1, "R4 protected write error", er, 1);
    xfer(0, 0, 3, 0, 0, rd, er, w);
    check(er == 1 && rd == 0, "R4 protected read zero", rd, 0);
    xfer(0, 0, 3, 0, 1, rd, er, w);
    check(rd == 32'hCAFE_0003, "R4 write discarded", rd, 32'hCAFE_0003);
  endtask

  task automatic t_range();
    logic [31:0] rd; bit er; int w;
    xfer(1, 1, 16, 32'h1234_5678, 1, rd, er, w);
    check(er == 1, "R8 out-of-range error", er, 1);
    xfer(0, 1, 0, 0, 1, rd, er, w);
    check(rd != 32'h1234_5678, "R8 no alias write", rd, 0);
    xfer(0, 1, 700, 0, 1, rd, er, w);
    check(er == 1 && rd == 0, "R8 out-of-range read", rd, 0);
  endtask

  task automatic t_auth();
    logic [31:0] rd; bit er; int w;
    xfer(1, 0, 5, 32'h1, 1, rd, er, w);
    xfer(0, 0, 5, 0, 1, rd, er, w);
    check(rd == 1, "R5 ctrl readback", rd, 1);
    @(negedge clk); sec_inv_en = 0;
    @(negedge clk);
    check(halt_su_ok == 0, "R6 halt blocked with pin low", halt_su_ok, 0);
    check(mon_su_ok == 1, "R7 monitor via bit", mon_su_ok, 1);
    sec_inv_en = 1;
    @(negedge clk);
    check(halt_su_ok == 1, "R6 halt with pin high", halt_su_ok, 1);
    xfer(1, 0, 5, 32'h0, 0, rd, er, w);
    check(er == 1, "R4 ctrl protected", er, 1);
    xfer(1, 0, 5, 32'h0, 1, rd, er, w);
    @(negedge clk); sec_inv_en = 0;
    @(negedge clk);
    check(mon_su_ok == 0, "R7 monitor off", mon_su_ok, 0);
    xfer(1, 1, 5, 32'h7, 1, rd, er, w);
    xfer(0, 0, 5, 0, 1, rd, er, w);
    check(rd == 0, "R2 perf word 5 not ctrl", rd, 0);
  endtask

  task automatic t_reset_clears();
    logic [31:0] rd; bit er; int w;
    xfer(1, 0, 5, 32'h1, 1, rd, er, w);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check(mon_su_ok == 0, "R9 monitor cleared", mon_su_ok, 0);
    xfer(0, 0, 5, 0, 1, rd, er, w);
    check(rd == 0, "R9 ctrl bit cleared", rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_debug_rw();
    t_perf_rw();
    t_protect();
    t_range();
    t_auth();
    t_reset_clears();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule